// File: doc/BRIEF.md
# Chip-Selected Serial/Parallel Shift Register

This block is a 16-stage shift register with two ways to fill it and one serial output. A mode input chooses the path. With mode high, the whole parallel word is captured at once. With mode low, a serial bit enters stage 0 and every stage moves one place toward the top. The serial output always shows the top stage, so a parallel word can be serialised most-significant bit first, or a serial stream can be delayed by the register length. Every state change happens on the falling clock edge.

An active-low select gates both paths. While select is high, the register keeps its contents. The select may only be released while the clock is low, because releasing it during the high phase can produce a false clock edge. A monitor samples the select on each rising edge and again on the next falling edge. When it sees the select go from active to released inside one high phase, it sets a hazard flag that only reset clears. Reset is synchronous and active high, is sampled on the falling edge, and takes priority over everything else.

Top module: `csel_piso_shreg`

## Requirements
- R1: The register state (and hence the serial output) changes only on a falling clock edge; a rising edge leaves the output unchanged.
- R2: With `rst`=0, `cs_n`=0 and `load_sel`=1, a falling edge copies `pdata[i]` into stage i for every i.
- R3: With `rst`=0, `cs_n`=0 and `load_sel`=0, a falling edge puts `ser_in` into stage 0 and moves stage i into stage i+1.
- R4: `ser_out` always equals the top stage (index 15 at the default width).
- R5: With `rst`=0 and `cs_n`=1, all stages keep their values whatever `load_sel`, `pdata` and `ser_in` are.
- R6: With `rst`=1 at a falling edge, all stages and the hazard flag become 0, even when `cs_n`=1.
- R7: `cs_hazard` becomes 1 at the falling edge that ends a high clock phase during which `cs_n` went from 0 to 1. A `cs_n` rise during the low phase does not set it.
- R8: Once set, `cs_hazard` stays 1 until a reset.
- R9: After a parallel load followed by continuous shifting, `ser_out` shows `pdata` bit 15 first and then bits 14 down to 0, one per falling edge.
- R10: A serially entered word leaves the output first bit first, and each bit reaches `ser_out` 15 falling edges after it enters stage 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| cs_n | input | 1 | Active-low select; high freezes the register |
| load_sel | input | 1 | 1 = parallel capture, 0 = serial shift |
| pdata | input | WIDTH (16) | Parallel word, bit i goes to stage i |
| ser_in | input | 1 | Serial bit entering stage 0 |
| ser_out | output | 1 | Top stage of the register |
| cs_hazard | output | 1 | Sticky flag for a select release during the high clock phase |

## Verification
Parallel words with alternating, single-bit, all-but-top and all-ones patterns are loaded and then shifted out. A wrong bit order or a dropped stage shows up as a wrong bit at the output. Serial streams with irregular bit runs measure the 15-edge latency and separate it from an off-by-one length. Select-high cycles mix both modes and changing data, and the full word is read out afterwards, so a leak through either path is caught. Select releases placed in the low phase and in the high phase tell a correct hazard monitor from one that is blind or fires too eagerly.

// File: rtl/csel_piso_pkg.sv
package csel_piso_pkg;

    localparam int unsigned DEF_WIDTH = 16;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_CLEAR = 2'd3
    } sr_op_e;

    typedef struct packed {
        sr_op_e op;
        logic   ser_bit;
    } sr_cmd_t;

    // Priority: reset, then select, then mode
    function automatic sr_op_e pick_op(input logic rst, input logic cs_n,
                                       input logic load_sel);
        if (rst)           return OP_CLEAR;
        else if (cs_n)     return OP_HOLD;
        else if (load_sel) return OP_LOAD;
        else               return OP_SHIFT;
    endfunction

endpackage

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode
    import csel_piso_pkg::*;
(
    input  logic    rst,
    input  logic    cs_n,
    input  logic    load_sel,
    input  logic    ser_in,
    output sr_cmd_t cmd
);
    always_comb begin
        cmd.op      = pick_op(rst, cs_n, load_sel);
        cmd.ser_bit = ser_in;
    end
endmodule

// File: rtl/sr_stage_array.sv
module sr_stage_array
    import csel_piso_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  sr_cmd_t          cmd,
    input  logic [WIDTH-1:0] pdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    for (genvar b = 0; b < WIDTH; b++) begin : g_stage
        logic shift_src;
        if (b == 0) begin : g_head
            assign shift_src = cmd.ser_bit;
        end else begin : g_body
            assign shift_src = q[b-1];
        end

        always_comb begin
            unique case (cmd.op)
                OP_CLEAR: nxt[b] = 1'b0;
                OP_LOAD:  nxt[b] = pdata[b];
                OP_SHIFT: nxt[b] = shift_src;
                default:  nxt[b] = q[b];
            endcase
        end
    end

    always_ff @(negedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/sr_cs_hazard_mon.sv
module sr_cs_hazard_mon (
    input  logic clk,
    input  logic clear,
    input  logic cs_n,
    output logic flag
);
    // Select level seen at the start of the high phase
    logic cs_n_at_rise;

    always_ff @(posedge clk) begin
        cs_n_at_rise <= cs_n;
    end

    // Active at the rising edge, released by the falling edge: released while high
    always_ff @(negedge clk) begin
        if (clear)
            flag <= 1'b0;
        else if (cs_n && !cs_n_at_rise)
            flag <= 1'b1;
    end
endmodule

// File: rtl/csel_piso_shreg.sv
module csel_piso_shreg
    import csel_piso_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             load_sel,
    input  logic [WIDTH-1:0] pdata,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             cs_hazard
);
    localparam int unsigned TOP = WIDTH - 1;

    sr_cmd_t          cmd;
    logic [WIDTH-1:0] stage_q;

    sr_cmd_decode u_dec (
        .rst      (rst),
        .cs_n     (cs_n),
        .load_sel (load_sel),
        .ser_in   (ser_in),
        .cmd      (cmd)
    );

    sr_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk   (clk),
        .cmd   (cmd),
        .pdata (pdata),
        .q     (stage_q)
    );

    sr_cs_hazard_mon u_haz (
        .clk   (clk),
        .clear (rst),
        .cs_n  (cs_n),
        .flag  (cs_hazard)
    );

    assign ser_out = stage_q[TOP];
endmodule

// File: rtl/csel_piso_shreg_chk.sv
module csel_piso_shreg_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             load_sel,
    input logic [WIDTH-1:0] pdata,
    input logic             ser_in,
    input logic             cs_hazard,
    input logic [WIDTH-1:0] q
);
    assert_load_R2: assert property (@(negedge clk) disable iff (rst)
        (!cs_n && load_sel) |=> (q == $past(pdata)));

    assert_shift_R3: assert property (@(negedge clk) disable iff (rst)
        (!cs_n && !load_sel) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

    assert_hold_R5: assert property (@(negedge clk) disable iff (rst)
        cs_n |=> $stable(q));

    assert_clear_R6: assert property (@(negedge clk)
        rst |=> (q == '0 && !cs_hazard));

    assert_sticky_R8: assert property (@(negedge clk) disable iff (rst)
        cs_hazard |=> cs_hazard);
endmodule

bind csel_piso_shreg csel_piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .load_sel  (load_sel),
    .pdata     (pdata),
    .ser_in    (ser_in),
    .cs_hazard (cs_hazard),
    .q         (stage_q)
);

// File: tb/csel_piso_shreg_tb.sv
module csel_piso_shreg_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst, cs_n, load_sel, ser_in;
    logic [W-1:0] pdata;
    logic         ser_out, cs_hazard;
    int           n_chk = 0;
    int           n_bad = 0;

    always #2 clk = ~clk;

    csel_piso_shreg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .load_sel(load_sel),
        .pdata(pdata), .ser_in(ser_in), .ser_out(ser_out), .cs_hazard(cs_hazard)
    );

    // Row layout: rst, cs_n, load_sel, ser_in, pdata[15:0], expected ser_out
    localparam logic [20:0] VEC [12] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'hA5F0, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h8000, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h7FFF, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One falling edge, then sample while the clock is low
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic r, input logic c, input logic m,
                         input logic s, input logic [W-1:0] d);
        rst = r; cs_n = c; load_sel = m; ser_in = s; pdata = d;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
        tick(); tick();
        check("R6 reset ser_out", ser_out, 1'b0);
        check("R6 reset flag", cs_hazard, 1'b0);

        // Table walk: R2 load, R3 shift, R4 output, R5 hold
        for (int i = 0; i < 12; i++) begin
            drive(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:1]);
            tick();
            check($sformatf("R2/R3/R4/R5 row %0d", i), ser_out, VEC[i][0]);
            check("R7 no hazard in table", cs_hazard, 1'b0);
        end

        // R1: a rising edge does nothing; state is 16'hFFFE here
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        @(posedge clk); #1;
        check("R1 rising edge no change", ser_out, 1'b1);
        tick();
        check("R1 falling edge load", ser_out, 1'b0);

        // R5: hold while select high, then read whole word
        word = 16'h1234;
        drive(1'b0, 1'b0, 1'b1, 1'b0, word); tick();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 16'hEDCB); tick();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF); tick();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000); tick();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        for (int k = 0; k < W; k++) begin
            check($sformatf("R5 held bit %0d", W-1-k), ser_out, word[W-1-k]);
            tick();
        end

        // R9: load then shift out top bit first
        word = 16'hC3A5;
        drive(1'b0, 1'b0, 1'b1, 1'b0, word); tick();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        for (int k = 0; k < W; k++) begin
            check($sformatf("R9 order step %0d", k), ser_out, word[W-1-k]);
            tick();
        end

        // R10: serial word, first bit out after 15 more edges
        word = 16'hB38D;
        for (int i = 0; i < W; i++) begin
            drive(1'b0, 1'b0, 1'b0, word[W-1-i], 16'h0000);
            tick();
            if (i == W-2) check("R10 not yet at output", ser_out, 1'b0);
        end
        check("R10 first bit latency", ser_out, word[W-1]);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        for (int k = 1; k < W; k++) begin
            tick();
            check($sformatf("R10 bit %0d", k), ser_out, word[W-1-k]);
        end

        // R7: release during low phase is safe
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000); tick(); tick();
        check("R7 low-phase release", cs_hazard, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000); tick();
        // R7: release during high phase
        @(posedge clk); #1;
        cs_n = 1'b1;
        tick();
        check("R7 high-phase release", cs_hazard, 1'b1);

        // R8: flag stays through normal operation
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF); tick();
        check("R8 sticky after load", cs_hazard, 1'b1);
        check("R2 load all ones", ser_out, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000); tick();
        check("R8 sticky after shift", cs_hazard, 1'b1);

        // R6: reset wins over select high
        drive(1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF); tick();
        check("R6 reset clears flag", cs_hazard, 1'b0);
        check("R6 reset clears output", ser_out, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        for (int k = 0; k < W; k++) begin
            tick();
            check("R6 all stages zero", ser_out, 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule